// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block receives characters from a single asynchronous serial line. An oversample strobe that runs at sixteen times the bit rate paces it. The line first passes through a two-flop synchroniser. A falling edge is a drop to low after the line has been seen high. The receiver treats that edge as a possible start bit and checks the line again at the middle of the bit. If the line is high by then, the edge is taken as a glitch and the receiver goes back to idle.

After a confirmed start, the receiver samples five to eight data bits, least significant bit first, at the middle of each bit. A parity bit may follow the data bits. One stop bit comes last. The character is handed out zero-extended to eight bits, with a one-cycle valid strobe and two flags: a parity mismatch and a low stop bit. The word length, parity enable and parity sense are captured when the start edge is detected, so the host may change them while a character is in flight.

Only the first stop bit is sampled. Just after that sample the receiver can take a new start edge, so characters sent with longer stop periods also arrive correctly back to back.

Top module: `serial_rx_core`

## Requirements
- R1: The length code `cfg_len` selects the number of data bits: 0 selects 5, 1 selects 6, 2 selects 7 and 3 selects 8. The first data bit after the start bit goes to bit 0 of `rx_data`.
- R2: When a character has fewer than 8 bits, the bits of `rx_data` above its length are 0.
- R3: With `cfg_par_en`=1, the bit that follows the last data bit is taken as parity. With `cfg_par_even`=1 the data bits and the parity bit must hold an even number of ones; with 0 they must hold an odd number. If the count does not match, `rx_par_err` is 1 with the character.
- R4: With `cfg_par_en`=0 no parity bit is expected, the bit after the last data bit is read as the stop bit, and `rx_par_err` stays 0.
- R5: If the first stop bit is sampled low, `rx_frm_err` is 1 and the character is still delivered.
- R6: Only the first stop bit is examined. Characters with 1, 1.5 or 2 stop periods and no idle gap between them are all received.
- R7: A low pulse that has ended before the middle of the start bit (8 oversample ticks) produces no character.
- R8: `rx_valid` is high for exactly one clock per character. `rx_data`, `rx_par_err` and `rx_frm_err` hold their values until the next `rx_valid`.
- R9: After reset, `rx_valid`, `rx_data`, `rx_par_err` and `rx_frm_err` are all 0.
- R10: A new start needs the line to have been high first. A line that stays low after a framing error produces no further characters until it has returned high and then fallen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample strobe, one clock wide, 16 per bit |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par_en | input | 1 | 1 = parity bit expected |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | One-clock strobe, character ready |
| rx_par_err | output | 1 | Parity mismatch for the delivered character |
| rx_frm_err | output | 1 | First stop bit sampled low |

## Verification
Some checks run on every cycle. These cover the single-cycle valid strobe and outputs that hold between strobes (R8), zero upper data bits for the captured length (R2), and a parity flag that stays clear when parity is off (R4). Some behaviour only shows over whole frames, so only the bench scenarios can show it. This covers the bit order and word lengths, the parity sense, framing errors, glitch rejection, frames sent back to back with long stop periods, and the need for a high level before the next start.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP  = 3'd4
    } rx_state_e;

    // word length for a 2-bit length code: 5 + code
    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES   = 2,
    parameter bit IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/srx_parity.sv
module srx_parity #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          par_bit,
    input  logic          even_sel,
    output logic          mismatch
);

    logic ones_odd;

    // data arrives with unused upper bits cleared, so a full reduction is exact
    always_comb begin
        ones_odd = (^data) ^ par_bit;
        mismatch = even_sel ? ones_odd : ~ones_odd;
    end

endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_even,
    input  logic          par_mismatch,
    output logic [DW-1:0] acc_data,
    output logic          acc_par,
    output logic          acc_even,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output logic          out_perr,
    output logic          out_ferr
);

    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DW);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [1:0]      len;
        logic            pen;
        logic            pev;
        logic            armed;
        logic [DW-1:0]   acc;
        logic            pbit;
        logic [DW-1:0]   data;
        logic            valid;
        logic            perr;
        logic            ferr;
    } frame_t;

    frame_t q, d;
    logic   last_bit;
    logic   sample;

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        sample   = tick && (q.cnt == FULL_LAST);
        last_bit = ({1'b0, q.idx} == IDX_W'(word_bits(q.len) - 4'd1));

        unique case (q.state)
            RX_IDLE: begin
                if (line) d.armed = 1'b1;
                if (tick && !line && q.armed) begin
                    d.state = RX_START;
                    d.cnt   = '0;
                    d.acc   = '0;
                    d.len   = cfg_len;
                    d.pen   = cfg_par_en;
                    d.pev   = cfg_par_even;
                    d.armed = 1'b0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.cnt == HALF_LAST) begin
                        d.cnt   = '0;
                        d.idx   = '0;
                        d.state = line ? RX_IDLE : RX_DATA;
                        d.armed = line;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (sample) begin
                    d.cnt        = '0;
                    d.acc[q.idx] = line;
                    if (last_bit) d.state = q.pen ? RX_PAR : RX_STOP;
                    else          d.idx   = q.idx + 1'b1;
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_PAR: begin
                if (sample) begin
                    d.cnt   = '0;
                    d.pbit  = line;
                    d.state = RX_STOP;
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (sample) begin
                    d.cnt   = '0;
                    d.valid = 1'b1;
                    d.data  = q.acc;
                    d.perr  = q.pen && par_mismatch;
                    d.ferr  = !line;
                    d.armed = line;
                    d.state = RX_IDLE;
                end else if (tick) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign acc_data  = q.acc;
    assign acc_par   = q.pbit;
    assign acc_even  = q.pev;
    assign out_data  = q.data;
    assign out_valid = q.valid;
    assign out_perr  = q.perr;
    assign out_ferr  = q.ferr;

    // R8: the strobe never lasts two cycles
    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    // R8: outputs hold between strobes
    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.valid |-> ($stable(q.data) && $stable(q.perr) && $stable(q.ferr)));

    // R2: nothing above the captured length
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> ((q.data >> word_bits(q.len)) == '0));

    // R4: parity flag stays clear when parity was off for the character
    assert_no_perr_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && !q.pen) |-> !q.perr);

    // R5: a stop-low character is delivered as soon as the stop bit is sampled
    assert_ferr_delivered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == RX_STOP && sample && !line) |=> (q.valid && q.ferr));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
    parameter int OSR       = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_par_err,
    output logic       rx_frm_err
);

    localparam int DW = 8;

    logic          line_s;
    logic [DW-1:0] acc_data;
    logic          acc_par;
    logic          acc_even;
    logic          par_mismatch;

    srx_sync #(.STAGES(SYNC_STGS), .IDLE_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    srx_parity #(.DW(DW)) u_parity (
        .data    (acc_data),
        .par_bit (acc_par),
        .even_sel(acc_even),
        .mismatch(par_mismatch)
    );

    srx_frame #(.OSR(OSR), .DW(DW)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (os_tick),
        .line        (line_s),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_even(cfg_par_even),
        .par_mismatch(par_mismatch),
        .acc_data    (acc_data),
        .acc_par     (acc_par),
        .acc_even    (acc_even),
        .out_data    (rx_data),
        .out_valid   (rx_valid),
        .out_perr    (rx_par_err),
        .out_ferr    (rx_frm_err)
    );

endmodule

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;

    localparam int TDIV   = 4;
    localparam int BITCLK = TDIV * 16;
    localparam int NVEC   = 12;

    typedef struct packed {
        logic [1:0] len;
        logic       pen;
        logic       pev;
        logic [7:0] dat;
        logic       badp;
        logic       badstop;
        logic [5:0] stop_ticks;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 6'd16},
        '{2'd0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 6'd16},
        '{2'd1, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, 6'd16},
        '{2'd2, 1'b1, 1'b0, 8'h55, 1'b0, 1'b0, 6'd24},
        '{2'd3, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0, 6'd32},
        '{2'd3, 1'b1, 1'b0, 8'h7E, 1'b1, 1'b0, 6'd16},
        '{2'd0, 1'b1, 1'b0, 8'h13, 1'b0, 1'b0, 6'd24},
        '{2'd3, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 6'd16},
        '{2'd2, 1'b1, 1'b1, 8'h7F, 1'b0, 1'b1, 6'd32},
        '{2'd1, 1'b0, 1'b0, 8'h2A, 1'b1, 1'b0, 6'd16},
        '{2'd3, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 6'd32},
        '{2'd0, 1'b1, 1'b1, 8'h0A, 1'b1, 1'b0, 6'd16}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_par_err;
    logic       rx_frm_err;

    int errors = 0;
    int checks = 0;
    int n_got = 0;
    logic [7:0] got_data [64];
    logic       got_perr [64];
    logic       got_ferr [64];
    logic [3:0] tdiv_q = '0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) tdiv_q <= (tdiv_q == 4'(TDIV - 1)) ? 4'd0 : tdiv_q + 4'd1;
    assign os_tick = (tdiv_q == 4'(TDIV - 1));

    serial_rx_core dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .rx_line     (rx_line),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_even(cfg_par_even),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_par_err  (rx_par_err),
        .rx_frm_err  (rx_frm_err)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid && n_got < 64) begin
            got_data[n_got] = rx_data;
            got_perr[n_got] = rx_par_err;
            got_ferr[n_got] = rx_frm_err;
            n_got = n_got + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic val, input int nclk);
        rx_line = val;
        repeat (nclk) @(negedge clk);
    endtask

    task automatic send(input vec_t v, input int gap_clk);
        int nb;
        logic [7:0] m;
        logic pb;
        nb = 5 + int'(v.len);
        m  = v.dat & (8'hFF >> (3 - int'(v.len)));
        pb = v.pev ? (^m) : ~(^m);
        if (v.badp) pb = ~pb;
        cfg_len = v.len;
        cfg_par_en = v.pen;
        cfg_par_even = v.pev;
        drive(1'b0, BITCLK);
        for (int i = 0; i < nb; i++) drive(m[i], BITCLK);
        if (v.pen) drive(pb, BITCLK);
        if (v.badstop) begin
            drive(1'b0, BITCLK);
            drive(1'b1, int'(v.stop_ticks) * TDIV - BITCLK);
        end else begin
            drive(1'b1, int'(v.stop_ticks) * TDIV);
        end
        if (gap_clk > 0) drive(1'b1, gap_clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        @(negedge clk);
        @(negedge clk);
        // R9: reset values
        check("R9 valid", 32'(rx_valid), 0);
        check("R9 data", 32'(rx_data), 0);
        check("R9 perr", 32'(rx_par_err), 0);
        check("R9 ferr", 32'(rx_frm_err), 0);
        rst_n = 1'b1;
        drive(1'b1, 4 * BITCLK);

        // table walk, frames back to back unless the stop bit was forced low
        for (int k = 0; k < NVEC; k++)
            send(VECS[k], VECS[k].badstop ? 2 * BITCLK : 0);
        drive(1'b1, 2 * BITCLK);
        check("R6 count of back-to-back characters", 32'(n_got), NVEC);
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0] m;
            m = VECS[k].dat & (8'hFF >> (3 - int'(VECS[k].len)));
            check("R1 R2 data", 32'(got_data[k]), 32'(m));
            check("R3 R4 parity flag", 32'(got_perr[k]), 32'(VECS[k].pen & VECS[k].badp));
            check("R5 R6 framing flag", 32'(got_ferr[k]), 32'(VECS[k].badstop));
        end

        // R7: short low pulses must not start a character
        base = n_got;
        drive(1'b0, 5 * TDIV);
        drive(1'b1, 12 * BITCLK);
        drive(1'b0, 1);
        drive(1'b1, 12 * BITCLK);
        check("R7 glitch ignored", 32'(n_got), 32'(base));
        check("R8 data held after glitch", 32'(rx_data), 32'(got_data[NVEC-1]));

        // R10: line held low after a bad stop gives one character only
        base = n_got;
        send('{2'd3, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b1, 6'd16}, 0);
        drive(1'b0, 20 * BITCLK);
        check("R10 single character while low", 32'(n_got), 32'(base + 1));
        check("R5 framing flag with held low", 32'(rx_frm_err), 1);
        check("R5 data still delivered", 32'(rx_data), 32'h00C3);
        drive(1'b1, 2 * BITCLK);
        send('{2'd3, 1'b0, 1'b0, 8'h5A, 1'b0, 1'b0, 6'd16}, BITCLK);
        check("R10 recovery count", 32'(n_got), 32'(base + 2));
        check("R10 recovery data", 32'(rx_data), 32'h005A);
        check("R10 recovery framing flag", 32'(rx_frm_err), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule